// File: doc/BRIEF.md
# Widening Half-Precision Pair Dot-Accumulator

The block takes a single-precision accumulator and two 32-bit operands. Each operand carries two half-precision values. It forms the dot product of the two operand pairs, rounds that two-term sum once to single precision, and then adds the rounded value into the accumulator. That addition is a separate single-precision add with its own rounding. A negate control flips the signs of the first operand's two halves, which turns the accumulate into a subtract-of-products. A two-bit input picks one of four rounding directions.

A single request enters through a valid/ready handshake. The datapath spends one cycle on the fused dot product and one cycle on the accumulating add. The result then stays on the output until the consumer takes it. Subnormal inputs and subnormal results are handled as ordinary IEEE values. Every NaN result is the canonical quiet NaN. No exception flags are produced.

Top module: `fp16_dot_acc`

## Requirements
- R1: Lane pairing. The half in bits 15:0 of operand A is multiplied by the half in bits 15:0 of operand B. The half in bits 31:16 of A is multiplied by the half in bits 31:16 of B. The two products are summed. Lanes are never crossed.
- R2: The sum of the two products is formed exactly and rounded only once to single precision. Neither product is rounded on its own.
- R3: The rounded dot value is added to the accumulator in a second, separately rounded single-precision addition. The addition is not fused with the dot product.
- R4: When in_negate is 1, the sign bits of both halves of operand A (bits 15 and 31) are inverted before multiplication.
- R5: in_rmode selects the rounding direction for both roundings: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R6: Any NaN result is exactly 0x7FC00000. This covers NaN inputs, infinity times zero in either lane, and infinities of opposite sign in either sum.
- R7: Subnormal half and single inputs take part exactly. Single-precision subnormal results are produced. An overflow gives infinity or the largest finite value, as the rounding direction requires.
- R8: An exact-zero sum takes the shared sign if both terms carry the same sign. Otherwise it is +0, except under rounding toward -infinity, where it is -0.
- R9: in_ready is high only while no request is held. out_valid rises on the third rising edge counted from the accepting edge. out_valid and out_acc hold unchanged until out_ready is seen high, and in_ready returns on the next edge.
- R10: After a synchronous reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_acc | input | 32 | Single-precision accumulator |
| in_op_a | input | 32 | Two half-precision values, lane 0 in bits 15:0 |
| in_op_b | input | 32 | Two half-precision values, lane 0 in bits 15:0 |
| in_negate | input | 1 | Invert the signs of operand A's halves |
| in_rmode | input | 2 | Rounding direction select |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 32 | New single-precision accumulator |

## Verification
A request accepted on one rising edge yields its dot value on the next edge and its final accumulator on the edge after that. out_valid is therefore first seen high after the third edge. From then on the result stays put for as many cycles as out_ready stays low. The bench keeps a phase counter that advances on the same edges. At each falling edge it compares in_ready, out_valid and, while a result is held, out_acc against that counter and against a queue of expected values. Those expected values come from exact wide-integer arithmetic. Because of this, stalls of any length are checked cycle by cycle.

// File: rtl/fp16dot_pkg.sv
package fp16dot_pkg;

    localparam int FIX_W   = 82;
    localparam int DOT_LSB = -48;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {ST_IDLE, ST_DOT, ST_ACC, ST_DONE} phase_e;

    typedef struct packed {
        logic [31:0] acc;
        logic [31:0] op_a;
        logic [31:0] op_b;
        rmode_e      rm;
    } dot_req_t;

    // value = sig * 2^ulp for finite numbers
    typedef struct packed {
        logic              sgn;
        logic              is_nan;
        logic              is_inf;
        logic              is_zero;
        logic [23:0]       sig;
        logic signed [9:0] ulp;
    } fpnum_t;

    function automatic fpnum_t unpack_h(input logic [15:0] h);
        fpnum_t r;
        r.sgn     = h[15];
        r.is_nan  = (&h[14:10]) & (|h[9:0]);
        r.is_inf  = (&h[14:10]) & ~(|h[9:0]);
        r.is_zero = ~(|h[14:0]);
        r.sig     = {13'd0, |h[14:10], h[9:0]};
        r.ulp     = (h[14:10] == 5'd0) ? -10'sd24 : $signed({5'd0, h[14:10]}) - 10'sd25;
        return r;
    endfunction

    function automatic fpnum_t unpack_s(input logic [31:0] f);
        fpnum_t r;
        r.sgn     = f[31];
        r.is_nan  = (&f[30:23]) & (|f[22:0]);
        r.is_inf  = (&f[30:23]) & ~(|f[22:0]);
        r.is_zero = ~(|f[30:0]);
        r.sig     = {|f[30:23], f[22:0]};
        r.ulp     = (f[30:23] == 8'd0) ? -10'sd149 : $signed({2'd0, f[30:23]}) - 10'sd150;
        return r;
    endfunction

    function automatic logic zero_sign(input logic sa, input logic sb, input rmode_e rm);
        return (sa == sb) ? sa : (rm == RM_DOWN);
    endfunction

    function automatic logic [31:0] overflow_val(input logic sgn, input rmode_e rm);
        logic to_inf;
        case (rm)
            RM_NEAREST: to_inf = 1'b1;
            RM_ZERO:    to_inf = 1'b0;
            RM_UP:      to_inf = ~sgn;
            default:    to_inf = sgn;
        endcase
        return to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7F_FFFF};
    endfunction

    // Round the nonzero value mag * 2^ex to single precision.
    function automatic logic [31:0] round_fp32(input logic sgn, input logic [FIX_W-1:0] mag,
                                               input int ex, input rmode_e rm);
        int p, e, q, s, be;
        logic [FIX_W-1:0] kept;
        logic g, st, inc;
        logic [24:0] k25;
        p = 0;
        for (int i = 0; i < FIX_W; i++) if (mag[i]) p = i;
        e = p + ex;
        q = e - 23;
        if (q < -149) q = -149;
        s = q - ex;
        g  = 1'b0;
        st = 1'b0;
        if (s <= 0) begin
            kept = mag << (-s);
        end else begin
            kept = mag >> s;
            g    = mag[s-1];
            st   = |(mag & ((FIX_W'(1) << (s - 1)) - FIX_W'(1)));
        end
        case (rm)
            RM_NEAREST: inc = g & (st | kept[0]);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = (g | st) & ~sgn;
            default:    inc = (g | st) & sgn;
        endcase
        k25 = kept[24:0] + 25'(inc);
        if (k25[24]) begin
            k25 = k25 >> 1;
            q   = q + 1;
        end
        if (!k25[23]) return {sgn, 8'd0, k25[22:0]};
        be = q + 150;
        if (be >= 255) return overflow_val(sgn, rm);
        return {sgn, be[7:0], k25[22:0]};
    endfunction

endpackage

// File: rtl/fp16_pair_dot.sv
module fp16_pair_dot
    import fp16dot_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  rmode_e      rm,
    output logic [31:0] dot
);
    localparam int LANES = 2;
    localparam int HW    = 16;

    logic [LANES-1:0] p_sgn, p_inf, p_nan;
    logic [FIX_W-1:0] p_mag [LANES];

    // Exact lane products, aligned to a common 2^DOT_LSB grid
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fpnum_t xa, xb;
        assign xa = unpack_h(op_a[HW*l +: HW]);
        assign xb = unpack_h(op_b[HW*l +: HW]);
        assign p_sgn[l] = xa.sgn ^ xb.sgn;
        assign p_nan[l] = xa.is_nan | xb.is_nan | (xa.is_inf & xb.is_zero) | (xa.is_zero & xb.is_inf);
        assign p_inf[l] = xa.is_inf | xb.is_inf;
        assign p_mag[l] = (FIX_W'(xa.sig[10:0]) * FIX_W'(xb.sig[10:0]))
                          << (int'(xa.ulp) + int'(xb.ulp) - DOT_LSB);
    end

    always_comb begin
        logic [FIX_W-1:0] mag;
        logic s;
        mag = '0;
        s   = 1'b0;
        if (p_sgn[0] == p_sgn[1]) begin
            mag = p_mag[0] + p_mag[1];
            s   = p_sgn[0];
        end else if (p_mag[0] >= p_mag[1]) begin
            mag = p_mag[0] - p_mag[1];
            s   = p_sgn[0];
        end else begin
            mag = p_mag[1] - p_mag[0];
            s   = p_sgn[1];
        end
        if ((|p_nan) || ((&p_inf) && (p_sgn[0] != p_sgn[1])))
            dot = QNAN;
        else if (|p_inf)
            dot = {p_inf[0] ? p_sgn[0] : p_sgn[1], 8'hFF, 23'd0};
        else if (mag == '0)
            dot = {zero_sign(p_sgn[0], p_sgn[1], rm), 31'd0};
        else
            dot = round_fp32(s, mag, DOT_LSB, rm);
    end
endmodule

// File: rtl/fp32_acc_add.sv
module fp32_acc_add
    import fp16dot_pkg::*;
(
    input  logic [31:0] acc,
    input  logic [31:0] dot,
    input  rmode_e      rm,
    output logic [31:0] sum
);
    localparam int SIG_W = 24;
    localparam int EXT_W = SIG_W + 3;   // guard, round, sticky

    always_comb begin
        fpnum_t ux, uy, hi, lo;
        logic [EXT_W-1:0] hx, lx, lfull;
        logic [EXT_W:0] r;
        logic rs;
        int d;
        ux = unpack_s(acc);
        uy = unpack_s(dot);
        if (uy.ulp > ux.ulp) begin
            hi = uy; lo = ux;
        end else begin
            hi = ux; lo = uy;
        end
        d     = int'(hi.ulp) - int'(lo.ulp);
        hx    = {hi.sig, 3'b000};
        lfull = {lo.sig, 3'b000};
        if (d >= EXT_W)
            lx = {{(EXT_W-1){1'b0}}, |lo.sig};
        else
            lx = (lfull >> d) | {{(EXT_W-1){1'b0}}, |(lfull & ((EXT_W'(1) << d) - EXT_W'(1)))};
        if (hi.sgn == lo.sgn) begin
            r = {1'b0, hx} + {1'b0, lx};
            rs = hi.sgn;
        end else if (hx >= lx) begin
            r = {1'b0, hx - lx};
            rs = hi.sgn;
        end else begin
            r = {1'b0, lx - hx};
            rs = lo.sgn;
        end
        if (ux.is_nan | uy.is_nan | (ux.is_inf & uy.is_inf & (ux.sgn != uy.sgn)))
            sum = QNAN;
        else if (ux.is_inf)
            sum = {ux.sgn, 8'hFF, 23'd0};
        else if (uy.is_inf)
            sum = {uy.sgn, 8'hFF, 23'd0};
        else if (r == '0)
            sum = {zero_sign(ux.sgn, uy.sgn, rm), 31'd0};
        else
            sum = round_fp32(rs, FIX_W'(r), int'(hi.ulp) - 3, rm);
    end
endmodule

// File: rtl/fp16_dot_acc.sv
module fp16_dot_acc
    import fp16dot_pkg::*;
#(
    parameter logic [31:0] NEG_MASK = 32'h8000_8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_acc,
    input  logic [31:0] in_op_a,
    input  logic [31:0] in_op_b,
    input  logic        in_negate,
    input  logic [1:0]  in_rmode,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_acc
);
    phase_e      state_q;
    dot_req_t    req_q;
    logic [31:0] dot_q, res_q, dot_w, sum_w;

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_DONE);
    assign out_acc   = res_q;

    fp16_pair_dot u_dot (
        .op_a (req_q.op_a),
        .op_b (req_q.op_b),
        .rm   (req_q.rm),
        .dot  (dot_w)
    );

    fp32_acc_add u_add (
        .acc (req_q.acc),
        .dot (dot_q),
        .rm  (req_q.rm),
        .sum (sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            dot_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (in_valid) begin
                    req_q.acc  <= in_acc;
                    req_q.op_a <= in_op_a ^ (in_negate ? NEG_MASK : 32'd0);
                    req_q.op_b <= in_op_b;
                    req_q.rm   <= rmode_e'(in_rmode);
                    state_q    <= ST_DOT;
                end
                ST_DOT: begin
                    dot_q   <= dot_w;
                    state_q <= ST_ACC;
                end
                ST_ACC: begin
                    res_q   <= sum_w;
                    state_q <= ST_DONE;
                end
                default: if (out_ready) state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a held result does not move while the consumer stalls
    a_r9_hold_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_acc));

    // R9: a result appears exactly three edges after its accept
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready, 3));

    // R9: taking the result frees the input side on the next edge
    a_r9_ready_after: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> in_ready);

    // R6: any NaN leaving the block is the canonical one
    a_r6_out_nan: assert property (@(posedge clk) disable iff (rst)
        out_valid && (&out_acc[30:23]) && (|out_acc[22:0]) |-> out_acc == QNAN);

    // R6: any NaN from the dot stage is the canonical one
    a_r6_dot_nan: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACC) && (&dot_q[30:23]) && (|dot_q[22:0]) |-> dot_q == QNAN);
endmodule

// File: tb/fp16_dot_acc_tb_top.sv
module fp16_dot_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_acc = '0, in_op_a = '0, in_op_b = '0;
    logic        in_negate = 1'b0;
    logic [1:0]  in_rmode = 2'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_acc;

    int n_checks = 0;
    int n_errors = 0;
    int phase = 0;
    bit running = 1'b0;
    string cur_tag = "";

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    fp16_dot_acc dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_acc(in_acc), .in_op_a(in_op_a), .in_op_b(in_op_b),
        .in_negate(in_negate), .in_rmode(in_rmode),
        .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc)
    );

    // ---------------- exact reference (fixed point, scale 2^-160) ----------------
    localparam logic [31:0] DEF_NAN = 32'h7FC0_0000;

    function automatic int h_ulp(input logic [15:0] h);
        return (h[14:10] == 5'd0) ? -24 : int'(h[14:10]) - 25;
    endfunction
    function automatic logic [319:0] h_sig(input logic [15:0] h);
        return 320'({h[14:10] != 5'd0, h[9:0]});
    endfunction
    function automatic logic signed [319:0] s_fix(input logic [31:0] f);
        logic [319:0] m;
        int u;
        u = (f[30:23] == 8'd0) ? -149 : int'(f[30:23]) - 150;
        m = 320'({f[30:23] != 8'd0, f[22:0]}) << (u + 160);
        return f[31] ? -m : m;
    endfunction

    function automatic logic [31:0] ref_round(input logic signed [319:0] v, input logic [1:0] rm);
        logic [319:0] mag, kept, rem, half;
        bit sgn, up, to_inf;
        int msb, q, sh, be;
        sgn = v[319];
        mag = sgn ? -v : v;
        msb = 0;
        for (int i = 0; i < 320; i++) if (mag[i]) msb = i;
        q = msb - 160 - 23;
        if (q < -149) q = -149;
        sh   = q + 160;
        kept = mag >> sh;
        rem  = mag - (kept << sh);
        half = 320'(1) << (sh - 1);
        case (rm)
            2'd0: up = (rem > half) || (rem == half && kept[0]);
            2'd1: up = 1'b0;
            2'd2: up = (rem != 0) && !sgn;
            default: up = (rem != 0) && sgn;
        endcase
        kept = kept + 320'(up);
        if (kept == (320'(1) << 24)) begin
            kept = kept >> 1;
            q = q + 1;
        end
        if (kept < (320'(1) << 23)) return {sgn, 8'd0, kept[22:0]};
        be = q + 150;
        if (be >= 255) begin
            case (rm)
                2'd0: to_inf = 1'b1;
                2'd1: to_inf = 1'b0;
                2'd2: to_inf = !sgn;
                default: to_inf = sgn;
            endcase
            return to_inf ? {sgn, 31'h7F80_0000} : {sgn, 31'h7F7F_FFFF};
        end
        return {sgn, be[7:0], kept[22:0]};
    endfunction

    function automatic logic [31:0] ref_dot(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm);
        logic signed [319:0] v, term;
        logic [15:0] ha, hb;
        bit nan;
        bit [1:0] inf, ps;
        bit na, nb, ia, ib, za, zb;
        v = '0; nan = 0; inf = '0; ps = '0;
        for (int l = 0; l < 2; l++) begin
            ha = a[16*l +: 16];
            hb = b[16*l +: 16];
            ps[l] = ha[15] ^ hb[15];
            na = (ha[14:10] == 5'h1F) && (ha[9:0] != 0);
            nb = (hb[14:10] == 5'h1F) && (hb[9:0] != 0);
            ia = (ha[14:10] == 5'h1F) && (ha[9:0] == 0);
            ib = (hb[14:10] == 5'h1F) && (hb[9:0] == 0);
            za = (ha[14:0] == 0);
            zb = (hb[14:0] == 0);
            if (na || nb || (ia && zb) || (za && ib)) nan = 1;
            else if (ia || ib) inf[l] = 1;
            else begin
                term = (h_sig(ha) * h_sig(hb)) << (h_ulp(ha) + h_ulp(hb) + 160);
                v = ps[l] ? v - term : v + term;
            end
        end
        if (nan || (inf == 2'b11 && ps[0] != ps[1])) return DEF_NAN;
        if (inf[0]) return {ps[0], 31'h7F80_0000};
        if (inf[1]) return {ps[1], 31'h7F80_0000};
        if (v == 0) return {(ps[0] == ps[1]) ? ps[0] : (rm == 2'd3), 31'd0};
        return ref_round(v, rm);
    endfunction

    function automatic logic [31:0] ref_add(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm);
        logic signed [319:0] v;
        bit nx, ny, ix, iy;
        nx = (x[30:23] == 8'hFF) && (x[22:0] != 0);
        ny = (y[30:23] == 8'hFF) && (y[22:0] != 0);
        ix = (x[30:23] == 8'hFF) && (x[22:0] == 0);
        iy = (y[30:23] == 8'hFF) && (y[22:0] == 0);
        if (nx || ny || (ix && iy && x[31] != y[31])) return DEF_NAN;
        if (ix) return x;
        if (iy) return y;
        v = s_fix(x) + s_fix(y);
        if (v == 0) return {(x[31] == y[31]) ? x[31] : (rm == 2'd3), 31'd0};
        return ref_round(v, rm);
    endfunction

    function automatic logic [31:0] ref_full(input logic [31:0] acc, input logic [31:0] a,
                                             input logic [31:0] b, input bit neg, input logic [1:0] rm);
        logic [31:0] ea;
        ea = neg ? (a ^ 32'h8000_8000) : a;
        return ref_add(acc, ref_dot(ea, b, rm), rm);
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, expv);
        end
    endtask

    // cycle model: 0 idle, 1 dot, 2 accumulate, 3 holding result
    always @(posedge clk) begin
        if (rst) phase <= 0;
        else case (phase)
            0: if (in_valid) begin
                exp_q.push_back('{ref_full(in_acc, in_op_a, in_op_b, in_negate, in_rmode), cur_tag});
                phase <= 1;
            end
            1: phase <= 2;
            2: phase <= 3;
            default: if (out_ready) begin
                phase <= 0;
                void'(exp_q.pop_front());
            end
        endcase
    end

    always @(negedge clk) begin
        if (running && !rst) begin
            chk(in_ready === (phase == 0), "R9", "in_ready", 32'(in_ready), 32'(phase == 0));
            chk(out_valid === (phase == 3), "R9", "out_valid", 32'(out_valid), 32'(phase == 3));
            if (phase == 3 && exp_q.size() > 0)
                chk(out_acc === exp_q[0].val, exp_q[0].tag, "out_acc", out_acc, exp_q[0].val);
        end
    end

    always @(negedge clk) begin
        if (running) out_ready <= ($urandom_range(0, 9) < 7);
    end

    task automatic send(input logic [31:0] acc, input logic [31:0] a, input logic [31:0] b,
                        input bit neg, input logic [1:0] rm, input string tag,
                        input bit has_hand, input logic [31:0] hand);
        logic [31:0] r;
        if (has_hand) begin
            r = ref_full(acc, a, b, neg, rm);
            chk(r === hand, tag, "hand value", r, hand);
        end
        @(negedge clk);
        cur_tag = tag;
        in_valid = 1'b1; in_acc = acc; in_op_a = a; in_op_b = b;
        in_negate = neg; in_rmode = rm;
        while (in_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [15:0] rnd_h();
        logic [15:0] h;
        h = 16'($urandom);
        if ($urandom_range(0, 15) != 0 && h[14:10] == 5'h1F) h[14] = 1'b0;
        return h;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] acc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
        chk(in_ready === 1'b1, "R10", "in_ready in reset", 32'(in_ready), 32'd1);
        rst = 1'b0;
        running = 1'b1;

        send(32'h0, 32'h3C00_4000, 32'h4200_4400, 0, 2'd0, "R1", 1, 32'h4130_0000);
        send(32'h0, 32'h3C00_3C00, 32'h3C00_3C00, 0, 2'd0, "R1", 1, 32'h4000_0000);
        send(32'h0, 32'h3C00_4000, 32'h4200_4400, 1, 2'd0, "R4", 1, 32'hC130_0000);
        send(32'hBF80_0000, 32'h0001_3C00, 32'h0001_3C00, 0, 2'd2, "R2", 1, 32'h3400_0000);
        send(32'h3F80_0000, 32'h0001_0001, 32'h0001_3C00, 0, 2'd0, "R3", 1, 32'h3F80_0000);
        send(32'h0, 32'h0001_3C00, 32'h0001_3C00, 1, 2'd1, "R5", 1, 32'hBF80_0000);
        send(32'h0, 32'h0001_3C00, 32'h0001_3C00, 1, 2'd3, "R5", 1, 32'hBF80_0001);
        send(32'h0, 32'h0001_3C00, 32'h0001_3C00, 1, 2'd0, "R5", 1, 32'hBF80_0000);
        send(32'h0, 32'h0000_7C00, 32'h3C00_0000, 0, 2'd0, "R6", 1, 32'h7FC0_0000);
        send(32'h0, 32'h7E01_3C00, 32'h3C00_3C00, 0, 2'd0, "R6", 1, 32'h7FC0_0000);
        send(32'hFF80_0000, 32'h0000_7C00, 32'h0000_3C00, 0, 2'd0, "R6", 1, 32'h7FC0_0000);
        send(32'h0, 32'h0000_0001, 32'h0000_0001, 0, 2'd0, "R7", 1, 32'h2780_0000);
        send(32'h7F7F_FFFF, 32'h0000_3C00, 32'h0000_3C00, 0, 2'd2, "R7", 1, 32'h7F80_0000);
        send(32'h7F7F_FFFF, 32'h0000_3C00, 32'h0000_3C00, 0, 2'd1, "R7", 1, 32'h7F7F_FFFF);
        send(32'h0000_0001, 32'h0, 32'h0, 0, 2'd0, "R7", 1, 32'h0000_0001);
        send(32'h8000_0000, 32'h8000_8000, 32'h3C00_3C00, 0, 2'd0, "R8", 1, 32'h8000_0000);
        send(32'h0000_0000, 32'h8000_8000, 32'h3C00_3C00, 0, 2'd0, "R8", 1, 32'h0000_0000);
        send(32'h0000_0000, 32'h8000_8000, 32'h3C00_3C00, 0, 2'd3, "R8", 1, 32'h8000_0000);

        for (int i = 0; i < 400; i++) begin
            if (i % 2 == 0) acc = $urandom;
            else acc = {1'($urandom), 8'($urandom_range(90, 160)), 23'($urandom)};
            send(acc, {rnd_h(), rnd_h()}, {rnd_h(), rnd_h()}, 1'($urandom),
                 2'($urandom), "R2 R3 R7 random", 0, 32'h0);
        end

        while (phase != 0 || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule